// File: doc/BRIEF.md
# ASID-Tagged Address Translator

The block turns one 32-bit virtual address per request into a 29-bit physical address. Pages are 4 KB: the low 12 address bits pass through unchanged and only the 20-bit virtual page number is mapped. The three top address bits pick a region, and the region decides how the address is handled:

- **Lookup regions:** the user/low-kernel region (`0x00000000`–`0x7FFFFFFF`) and the upper kernel-mapped region (`0xC0000000`–`0xDFFFFFFF`) go through a 16-entry fully-associative TLB.
- **Direct-mapped windows:** the two windows `0x80000000`–`0x9FFFFFFF` and `0xA0000000`–`0xBFFFFFFF` get a fixed translation with no lookup.
- **Control region:** `0xE0000000` and above is not translated at all.

Each TLB entry carries a valid bit, a page number, an 8-bit address space tag, a shared bit and a physical page number. Software loads entries through an index/data/write-enable port. A configuration write sets the current address space tag and the comparison mode. When no entry matches, the block raises a miss flag and gives no translation. Software then loads the entry and the requester retries the access. Changing the current tag never clears the TLB.

Top module: `asid_tlb_xlate`

## Requirements
- R1: After reset, no response is pending (`rspValid` low) and every TLB entry is invalid, so any lookup-region request misses.
- R2: Every request accepted on a rising edge produces exactly one response with `rspValid` high on the following edge. Back-to-back requests give back-to-back responses. With no request, `rspValid` and all flags are low.
- R3: A request whose bits [31:30] are `2'b10` returns `rspPaddr` = `reqVaddr[28:0]` with all flags low, whatever the TLB holds.
- R4: A request whose bits [31:29] are `3'b111` returns `rspRaw` high, `rspPaddr` = `reqVaddr[28:0]`, and the other flags low.
- R5: A request with bit 31 clear, or with bits [31:29] = `3'b110`, that hits exactly one permitted entry returns `{ppn, reqVaddr[11:0]}` with all flags low.
- R6: A lookup-region request that matches no valid entry returns `rspMiss` high and `rspPaddr` zero.
- R7: In multiple-space mode (`cfgMulti`=1), an entry matches only when its page number matches and its tag equals the current tag, or its shared bit is set.
- R8: In single-space mode (`cfgMulti`=0), an entry matches on page number alone. A single matching entry that is not shared and whose tag differs from the current tag returns `rspProt` high and `rspPaddr` zero. A shared entry still translates.
- R9: When two or more entries match, the response has `rspMulti` high, `rspMiss` and `rspProt` low, and `rspPaddr` zero. At most one of the four flags is ever high.
- R10: An entry write takes effect on the edge after `entWe` is sampled. A request presented in the same cycle as the write sees the old contents. Writing an entry with `entValid`=0 removes it.
- R11: Changing the current tag leaves all entries in place: switching back to an earlier tag translates as before without any reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqVaddr | input | 32 | Virtual address to translate |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAsid | input | 8 | New current address space tag |
| cfgMulti | input | 1 | New mode: 1 multiple-space, 0 single-space |
| entWe | input | 1 | TLB entry write strobe |
| entIdx | input | 4 | Entry slot to write |
| entValid | input | 1 | Valid bit of the written entry |
| entVpn | input | 20 | Virtual page number of the written entry |
| entAsid | input | 8 | Address space tag of the written entry |
| entShared | input | 1 | Shared bit of the written entry |
| entPpn | input | 17 | Physical page number of the written entry |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspPaddr | output | 29 | Physical address, zero on any error or miss |
| rspMiss | output | 1 | No matching entry |
| rspProt | output | 1 | Single-space tag protection violation |
| rspMulti | output | 1 | More than one entry matched |
| rspRaw | output | 1 | Address lies in the untranslated control region |

## Verification
The bench sends addresses from every region, so that the lookup path can be told apart from the two direct windows and from the untranslated region. It then replays the same page under several current tags in both modes. This separates a tag-qualified hit, a shared hit, a miss and a protection violation. Two entries with the same page but different tags show that multiple hits are flagged in single-space mode yet resolve cleanly in multiple-space mode. A write issued together with a request shows whether the new entry becomes visible one cycle late or too early.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  parameter int VA_W      = 32;
  parameter int PA_W      = 29;
  parameter int PAGE_BITS = 12;
  parameter int ASID_W    = 8;
  parameter int ENTRIES   = 16;

  localparam int VPN_W  = VA_W - PAGE_BITS;
  localparam int PPN_W  = PA_W - PAGE_BITS;
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int CNT_W  = IDX_W + 1;
  localparam int RGN_W  = VA_W - PA_W;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              shared;
    logic [PPN_W-1:0]  ppn;
  } tlbEntry_t;

  typedef enum logic [1:0] {
    RGN_LOOKUP = 2'd0,
    RGN_FIXED  = 2'd1,
    RGN_RAW    = 2'd2
  } region_e;

  typedef struct packed {
    logic load;
    logic selTlb;
    logic selDirect;
    logic flagMiss;
    logic flagProt;
    logic flagMulti;
    logic flagRaw;
  } ctrlStrobe_t;
endpackage

// File: rtl/tlbx_ctrl.sv
module tlbx_ctrl
  import tlbx_pkg::*;
(
  input  logic             reqValid,
  input  logic [RGN_W-1:0] vaddrTop,
  input  logic             lookupHit,
  input  logic             lookupMulti,
  input  logic             lookupProt,
  output ctrlStrobe_t      strb
);

  region_e region;

  always_comb begin
    unique casez (vaddrTop)
      3'b0??:  region = RGN_LOOKUP;
      3'b10?:  region = RGN_FIXED;
      3'b110:  region = RGN_LOOKUP;
      default: region = RGN_RAW;
    endcase
  end

  always_comb begin
    strb = '0;
    strb.load = reqValid;
    if (reqValid) begin
      unique case (region)
        RGN_LOOKUP: begin
          if (lookupMulti)     strb.flagMulti = 1'b1;
          else if (!lookupHit) strb.flagMiss  = 1'b1;
          else if (lookupProt) strb.flagProt  = 1'b1;
          else                 strb.selTlb    = 1'b1;
        end
        RGN_FIXED: strb.selDirect = 1'b1;
        default: begin
          strb.selDirect = 1'b1;
          strb.flagRaw   = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/tlbx_dp.sv
module tlbx_dp
  import tlbx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              cfgWe,
  input  logic [ASID_W-1:0] cfgAsid,
  input  logic              cfgMulti,
  input  logic              entWe,
  input  logic [IDX_W-1:0]  entIdx,
  input  tlbEntry_t         entData,
  input  ctrlStrobe_t       strb,
  output logic              lookupHit,
  output logic              lookupMulti,
  output logic              lookupProt,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              rspMiss,
  output logic              rspProt,
  output logic              rspMulti,
  output logic              rspRaw
);

  tlbEntry_t         tbl [ENTRIES];
  logic [ASID_W-1:0] curAsid;
  logic              multiMode;

  logic [ENTRIES-1:0] hitVec;
  logic [ENTRIES-1:0] violVec;
  logic [CNT_W-1:0]   hitCnt;
  logic [PPN_W-1:0]   ppnSel;

  wire [VPN_W-1:0]     reqVpn = reqVaddr[VA_W-1:PAGE_BITS];
  wire [PAGE_BITS-1:0] reqOff = reqVaddr[PAGE_BITS-1:0];

  // configuration register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAsid   <= '0;
      multiMode <= 1'b0;
    end else if (cfgWe) begin
      curAsid   <= cfgAsid;
      multiMode <= cfgMulti;
    end
  end

  // entry storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else if (entWe) begin
      tbl[entIdx] <= entData;
    end
  end

  // per-entry comparators
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    logic vpnEq, asidEq, permit;
    assign vpnEq  = tbl[g].valid && (tbl[g].vpn == reqVpn);
    assign asidEq = (tbl[g].asid == curAsid);
    assign permit = multiMode ? (tbl[g].shared || asidEq) : 1'b1;
    assign hitVec[g]  = vpnEq && permit;
    assign violVec[g] = vpnEq && !multiMode && !tbl[g].shared && !asidEq;
  end

  always_comb begin
    hitCnt = '0;
    ppnSel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hitCnt = hitCnt + CNT_W'(hitVec[i]);
      if (hitVec[i]) ppnSel = ppnSel | tbl[i].ppn;
    end
  end

  assign lookupHit   = |hitVec;
  assign lookupMulti = (hitCnt > CNT_W'(1));
  assign lookupProt  = |violVec;

  // response register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspPaddr <= '0;
      rspMiss  <= 1'b0;
      rspProt  <= 1'b0;
      rspMulti <= 1'b0;
      rspRaw   <= 1'b0;
    end else begin
      rspValid <= strb.load;
      rspMiss  <= strb.flagMiss;
      rspProt  <= strb.flagProt;
      rspMulti <= strb.flagMulti;
      rspRaw   <= strb.flagRaw;
      if (strb.selTlb)         rspPaddr <= {ppnSel, reqOff};
      else if (strb.selDirect) rspPaddr <= reqVaddr[PA_W-1:0];
      else                     rspPaddr <= '0;
    end
  end

endmodule

// File: rtl/asid_tlb_xlate.sv
module asid_tlb_xlate
  import tlbx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              cfgWe,
  input  logic [ASID_W-1:0] cfgAsid,
  input  logic              cfgMulti,
  input  logic              entWe,
  input  logic [IDX_W-1:0]  entIdx,
  input  logic              entValid,
  input  logic [VPN_W-1:0]  entVpn,
  input  logic [ASID_W-1:0] entAsid,
  input  logic              entShared,
  input  logic [PPN_W-1:0]  entPpn,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              rspMiss,
  output logic              rspProt,
  output logic              rspMulti,
  output logic              rspRaw
);

  ctrlStrobe_t strb;
  tlbEntry_t   entData;
  logic        lookupHit, lookupMulti, lookupProt;

  assign entData = '{valid: entValid, vpn: entVpn, asid: entAsid,
                     shared: entShared, ppn: entPpn};

  tlbx_ctrl uCtrl (
    .reqValid   (reqValid),
    .vaddrTop   (reqVaddr[VA_W-1:PA_W]),
    .lookupHit  (lookupHit),
    .lookupMulti(lookupMulti),
    .lookupProt (lookupProt),
    .strb       (strb)
  );

  tlbx_dp uDp (
    .clk        (clk),
    .rstN       (rstN),
    .reqVaddr   (reqVaddr),
    .cfgWe      (cfgWe),
    .cfgAsid    (cfgAsid),
    .cfgMulti   (cfgMulti),
    .entWe      (entWe),
    .entIdx     (entIdx),
    .entData    (entData),
    .strb       (strb),
    .lookupHit  (lookupHit),
    .lookupMulti(lookupMulti),
    .lookupProt (lookupProt),
    .rspValid   (rspValid),
    .rspPaddr   (rspPaddr),
    .rspMiss    (rspMiss),
    .rspProt    (rspProt),
    .rspMulti   (rspMulti),
    .rspRaw     (rspRaw)
  );

endmodule

// File: rtl/asid_tlb_xlate_chk.sv
module asid_tlb_xlate_chk
  import tlbx_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [VA_W-1:0] reqVaddr,
  input logic            rspValid,
  input logic [PA_W-1:0] rspPaddr,
  input logic            rspMiss,
  input logic            rspProt,
  input logic            rspMulti,
  input logic            rspRaw
);

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R2
  idle_flags_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(rspMiss || rspProt || rspMulti || rspRaw));

  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspMiss, rspProt, rspMulti, rspRaw}));

  // R6
  error_zero_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspMiss || rspProt || rspMulti)) |-> (rspPaddr == '0));

  // R3
  fixed_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqVaddr[VA_W-1 -: 2] == 2'b10) |=>
      (rspPaddr == $past(reqVaddr[PA_W-1:0]) && !rspMiss && !rspProt && !rspMulti && !rspRaw));

  // R4
  raw_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqVaddr[VA_W-1 -: 3] == 3'b111) |=>
      (rspRaw && rspPaddr == $past(reqVaddr[PA_W-1:0])));

endmodule

bind asid_tlb_xlate asid_tlb_xlate_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqVaddr(reqVaddr),
  .rspValid(rspValid),
  .rspPaddr(rspPaddr),
  .rspMiss (rspMiss),
  .rspProt (rspProt),
  .rspMulti(rspMulti),
  .rspRaw  (rspRaw)
);

// File: tb/asid_tlb_xlate_test.sv
`timescale 1ns/1ps
module asid_tlb_xlate_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgAsid = '0;
  logic        cfgMulti = 1'b0;
  logic        entWe = 1'b0;
  logic [3:0]  entIdx = '0;
  logic        entValid = 1'b0;
  logic [19:0] entVpn = '0;
  logic [7:0]  entAsid = '0;
  logic        entShared = 1'b0;
  logic [16:0] entPpn = '0;
  logic        rspValid;
  logic [28:0] rspPaddr;
  logic        rspMiss, rspProt, rspMulti, rspRaw;

  localparam logic [3:0] F_OK = 4'b0000, F_RAW = 4'b0001, F_MISS = 4'b0010,
                         F_PROT = 4'b0100, F_MULTI = 4'b1000;

  typedef struct {
    logic [28:0] pa;
    logic [3:0]  fl;
    int          rq;
    longint      cyc;
  } item_t;

  item_t  sb[$];
  int     nChk = 0, nBad = 0;
  longint cyc = 0;
  bit     done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  asid_tlb_xlate uut (.*);

  task automatic check(bit ok, int rq, string what, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic pushExp(logic [28:0] pa, logic [3:0] fl, int rq);
    item_t it;
    it.pa = pa; it.fl = fl; it.rq = rq; it.cyc = cyc + 1;
    sb.push_back(it);
  endtask

  // driver: one request, expectations into the scoreboard
  task automatic sendReq(logic [31:0] va, logic [28:0] pa, logic [3:0] fl, int rq);
    reqValid = 1'b1; reqVaddr = va;
    pushExp(pa, fl, rq);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic setCfg(logic [7:0] asid, logic multi);
    cfgWe = 1'b1; cfgAsid = asid; cfgMulti = multi;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setEnt(logic [3:0] idx, logic v, logic [19:0] vpn, logic [7:0] asid,
                        logic sh, logic [16:0] ppn);
    entWe = 1'b1; entIdx = idx; entValid = v; entVpn = vpn;
    entAsid = asid; entShared = sh; entPpn = ppn;
  endtask

  task automatic writeEnt(logic [3:0] idx, logic v, logic [19:0] vpn, logic [7:0] asid,
                          logic sh, logic [16:0] ppn);
    setEnt(idx, v, vpn, asid, sh, ppn);
    @(negedge clk);
    entWe = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (sb.size() == 0) begin
        check(1'b0, 2, "unexpected response", 1, 0);
      end else begin
        item_t e;
        e = sb.pop_front();
        check(cyc == e.cyc, 2, "response cycle", cyc, e.cyc);
        check(rspPaddr == e.pa, e.rq, "paddr", rspPaddr, e.pa);
        check({rspMulti, rspProt, rspMiss, rspRaw} == e.fl, e.rq, "flags",
              {rspMulti, rspProt, rspMiss, rspRaw}, e.fl);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL R2 watchdog: actual 1 expected 0");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rspValid == 1'b0, 1, "rspValid after reset", rspValid, 0);
    sendReq(32'h0000_1234, '0, F_MISS, 1);          // R1 empty TLB
    // R3 and R4: fixed windows and raw region, back to back
    sendReq(32'h8001_2345, 29'h0001_2345, F_OK, 3);
    sendReq(32'hA765_4321, 29'h0765_4321, F_OK, 3);
    sendReq(32'hE123_4567, 29'h0123_4567, F_RAW, 4);
    // load entries, multiple-space mode, tag 5
    setCfg(8'd5, 1'b1);
    writeEnt(4'd0, 1'b1, 20'h00001, 8'd5, 1'b0, 17'h00ABC);
    writeEnt(4'd1, 1'b1, 20'hC0002, 8'd5, 1'b0, 17'h1F000);
    writeEnt(4'd2, 1'b1, 20'h00003, 8'd9, 1'b1, 17'h00333);
    sendReq(32'h0000_1234, 29'h0ABC234, F_OK, 5);   // R5
    sendReq(32'hC000_2FFF, 29'h1F000FFF, F_OK, 5);  // R5 upper region
    sendReq(32'h0000_9000, '0, F_MISS, 6);          // R6 unknown page
    sendReq(32'h8000_1234, 29'h0000_1234, F_OK, 3); // R3 ignores TLB page 1
    // R7: tag switch
    setCfg(8'd7, 1'b1);
    sendReq(32'h0000_1234, '0, F_MISS, 7);
    sendReq(32'h0000_3010, 29'h0333010, F_OK, 7);   // shared
    // R11: back to tag 5, no reload
    setCfg(8'd5, 1'b1);
    sendReq(32'h0000_1234, 29'h0ABC234, F_OK, 11);
    // R8: single-space mode
    setCfg(8'd7, 1'b0);
    sendReq(32'h0000_1234, '0, F_PROT, 8);
    sendReq(32'h0000_3010, 29'h0333010, F_OK, 8);
    setCfg(8'd5, 1'b0);
    sendReq(32'h0000_1ABC, 29'h0ABCABC, F_OK, 8);
    // R9: duplicate page, different tag
    writeEnt(4'd3, 1'b1, 20'h00001, 8'd6, 1'b0, 17'h00444);
    sendReq(32'h0000_1000, '0, F_MULTI, 9);
    setCfg(8'd5, 1'b1);
    sendReq(32'h0000_1000, 29'h0ABC000, F_OK, 7);
    setCfg(8'd6, 1'b1);
    sendReq(32'h0000_1000, 29'h0444000, F_OK, 7);
    // R10: write and request in the same cycle
    setEnt(4'd4, 1'b1, 20'h00005, 8'd6, 1'b0, 17'h00555);
    sendReq(32'h0000_5008, '0, F_MISS, 10);
    entWe = 1'b0;
    sendReq(32'h0000_5008, 29'h0555008, F_OK, 10);
    writeEnt(4'd4, 1'b0, 20'h00005, 8'd6, 1'b0, 17'h00555);
    sendReq(32'h0000_5008, '0, F_MISS, 10);
    repeat (3) @(negedge clk);
    // R2: every request answered
    check(sb.size() == 0, 2, "pending responses", sb.size(), 0);
    finishRun();
  end
endmodule